// File: doc/BRIEF.md
# Fixed-Point Rounding and Averaging Unit

This unit takes a signed intermediate value, applies a rounding correction selected by a 2-bit rounding-mode input, and then shifts the value right arithmetically by a number of guard bits. It also performs averaging add and averaging subtract on two signed elements of 8, 16, 32 or 64 bits. For averaging, both elements are sign-extended to a width that cannot overflow, then combined exactly, rounded with one guard bit and halved. Every result is cut to the element width and sign-extended to 64 bits.

The unit has two pipeline stages and never stalls. Stage one selects and widens the operands, forms the exact sum or difference, and fixes the guard-bit count. Stage two applies the rounding correction to the unshifted value, shifts it and trims it to the element width. A lane of a vector datapath can issue a new operation on every cycle.

Top module: `fxr_round_avg_unit`

## Requirements
- R1: While reset is asserted, `valid_o` is 0 and `result_o` is 0.
- R2: `valid_o` equals `valid_i` from two clock edges earlier. The unit never stalls.
- R3: Mode 0 (round-to-nearest-up) returns floor(v / 2^gb + 1/2), where v is the exact wide value and gb is the guard-bit count.
- R4: Mode 1 (round-to-nearest-even) returns v / 2^gb rounded to the nearest integer. An exact tie goes to the even neighbour.
- R5: Mode 2 (round-down) returns floor(v / 2^gb), which is plain arithmetic-shift truncation.
- R6: Mode 3 (round-to-odd) sets bit gb of v before the shift, so bit 0 of every result is 1.
- R7: With gb = 0, modes 0, 1 and 2 return v unchanged, and mode 3 returns v with bit 0 set.
- R8: `op_i` = 1 (averaging add) returns (sext(a) + sext(b)), rounded with gb = 1 and shifted right by one. sext extends an element of the selected width, and the sum is exact. `shamt_i` is ignored.
- R9: `op_i` = 2 (averaging subtract) does the same as R8 with sext(a) − sext(b).
- R10: `op_i` = 0 (and the reserved code 3) rounds and shifts the full 64-bit signed `a_i` by gb = `shamt_i` (0 to 63). The element width is coded in `sew_i` as 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. Every result keeps its low element-width bits, sign-extended to 64 bits.
- R11: On cycles where `valid_o` is 0, `result_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation valid |
| op_i | input | 2 | 0 round-shift, 1 average add, 2 average subtract, 3 as 0 |
| sew_i | input | 2 | Element width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| vxrm_i | input | 2 | Rounding mode: 0 nearest-up, 1 nearest-even, 2 down, 3 odd |
| shamt_i | input | 6 | Guard-bit count for round-shift |
| a_i | input | 64 | First signed operand |
| b_i | input | 64 | Second signed operand (averaging only) |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Rounded result, sign-extended from the element width |

## Verification
In any cycle, stage two rounds one operation while stage one widens and combines the next. The bench drives back-to-back valid operations with random opcode, mode, width and shift, mixed with idle gaps, so that an averaging subtract can follow a round-shift with a different mode and width. A behavioural reference uses exact rational remainder arithmetic on 130-bit integers, and the output is compared with it on every clock. Directed stimulus covers exact ties, negative ties, a zero shift, a shift of 63, and extreme 8-bit averages whose halved result wraps at the element width.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
  typedef enum logic [1:0] {
    RM_RNU = 2'd0,
    RM_RNE = 2'd1,
    RM_RDN = 2'd2,
    RM_ROD = 2'd3
  } rnd_mode_e;

  typedef enum logic [1:0] {
    OP_RSHIFT  = 2'd0,
    OP_AVG_ADD = 2'd1,
    OP_AVG_SUB = 2'd2,
    OP_RSV     = 2'd3
  } fx_op_e;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } elem_w_e;

  localparam int NUM_EW = 4;
  localparam int MIN_EW = 8;
endpackage

// File: rtl/fxr_sew_sext.sv
module fxr_sew_sext
  import fxr_pkg::*;
#(
  parameter int IN_W  = 64,
  parameter int OUT_W = 66
) (
  input  elem_w_e          sew_i,
  input  logic [IN_W-1:0]  d_i,
  output logic [OUT_W-1:0] q_o
);
  logic [OUT_W-1:0] cand [NUM_EW];

  for (genvar gi = 0; gi < NUM_EW; gi++) begin : g_ew
    localparam int EW = MIN_EW << gi;
    if (OUT_W > EW) begin : g_ext
      assign cand[gi] = {{(OUT_W-EW){d_i[EW-1]}}, d_i[EW-1:0]};
    end else begin : g_cut
      assign cand[gi] = d_i[OUT_W-1:0];
    end
  end

  assign q_o = cand[sew_i];
endmodule

// File: rtl/fxr_prep.sv
module fxr_prep
  import fxr_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WIDE = XLEN + 2,
  parameter int SHW  = $clog2(XLEN)
) (
  input  fx_op_e           op_i,
  input  elem_w_e          sew_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  output logic [WIDE-1:0]  v_o,
  output logic [SHW-1:0]   gb_o
);
  logic [WIDE-1:0] sa, sb, full_a;

  fxr_sew_sext #(.IN_W(XLEN), .OUT_W(WIDE)) u_sext_a (.sew_i(sew_i), .d_i(a_i), .q_o(sa));
  fxr_sew_sext #(.IN_W(XLEN), .OUT_W(WIDE)) u_sext_b (.sew_i(sew_i), .d_i(b_i), .q_o(sb));

  assign full_a = {{(WIDE-XLEN){a_i[XLEN-1]}}, a_i};

  always_comb begin
    unique case (op_i)
      OP_AVG_ADD: begin
        v_o  = sa + sb;
        gb_o = SHW'(1);
      end
      OP_AVG_SUB: begin
        v_o  = sa - sb;
        gb_o = SHW'(1);
      end
      default: begin
        v_o  = full_a;
        gb_o = shamt_i;
      end
    endcase
  end
endmodule

// File: rtl/fxr_round_shift.sv
module fxr_round_shift
  import fxr_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WIDE = XLEN + 2,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [WIDE-1:0] v_i,
  input  logic [SHW-1:0]  gb_i,
  input  rnd_mode_e       mode_i,
  input  elem_w_e         sew_i,
  output logic [XLEN-1:0] res_o
);
  localparam logic [WIDE-1:0] ONE = WIDE'(1);

  logic [WIDE-1:0] half, keep_bit, adj, shifted;
  logic            g_bit, sticky, lsb;

  // weight of the most significant discarded bit; none when gb is zero
  assign half     = (gb_i == '0) ? '0 : (ONE << (gb_i - 1'b1));
  assign keep_bit = ONE << gb_i;
  assign g_bit    = |(v_i & half);
  assign sticky   = |(v_i & (half - ONE));
  assign lsb      = |(v_i & keep_bit);

  always_comb begin
    unique case (mode_i)
      RM_RNU: adj = v_i + half;
      RM_RNE: adj = (g_bit && !sticky && !lsb) ? v_i : v_i + half;
      RM_RDN: adj = v_i;
      default: adj = v_i | keep_bit;
    endcase
  end

  assign shifted = $signed(adj) >>> gb_i;

  fxr_sew_sext #(.IN_W(XLEN), .OUT_W(XLEN)) u_trim (
    .sew_i(sew_i), .d_i(shifted[XLEN-1:0]), .q_o(res_o)
  );
endmodule

// File: rtl/fxr_round_avg_unit.sv
module fxr_round_avg_unit
  import fxr_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic [1:0]      sew_i,
  input  logic [1:0]      vxrm_i,
  input  logic [SHW-1:0]  shamt_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o
);
  localparam int WIDE = XLEN + 2;

  logic [WIDE-1:0] p_v;
  logic [SHW-1:0]  p_gb;

  logic            s1_valid;
  logic [WIDE-1:0] s1_v;
  logic [SHW-1:0]  s1_gb;
  rnd_mode_e       s1_mode;
  elem_w_e         s1_sew;
  logic [XLEN-1:0] s2_res;

  fxr_prep #(.XLEN(XLEN), .WIDE(WIDE), .SHW(SHW)) u_prep (
    .op_i   (fx_op_e'(op_i)),
    .sew_i  (elem_w_e'(sew_i)),
    .shamt_i(shamt_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .v_o    (p_v),
    .gb_o   (p_gb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_v     <= '0;
      s1_gb    <= '0;
      s1_mode  <= RM_RNU;
      s1_sew   <= EW_8;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_v    <= p_v;
        s1_gb   <= p_gb;
        s1_mode <= rnd_mode_e'(vxrm_i);
        s1_sew  <= elem_w_e'(sew_i);
      end
    end
  end

  fxr_round_shift #(.XLEN(XLEN), .WIDE(WIDE), .SHW(SHW)) u_rnd (
    .v_i   (s1_v),
    .gb_i  (s1_gb),
    .mode_i(s1_mode),
    .sew_i (s1_sew),
    .res_o (s2_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) result_o <= s2_res;
    end
  end
endmodule

// File: rtl/fxr_round_avg_checker.sv
module fxr_round_avg_checker #(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [1:0]      op_i,
  input logic [1:0]      sew_i,
  input logic [1:0]      vxrm_i,
  input logic [SHW-1:0]  shamt_i,
  input logic [XLEN-1:0] a_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o
);
  logic [1:0] cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= '0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r1: assert (!valid_o && result_o == '0)
        else $error("reset state violated");
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != 2'd0 && !valid_o) |-> $stable(result_o));

  p_rod_lsb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd2 && valid_o && $past(vxrm_i, 2) == 2'd3) |-> result_o[0]);

  p_zero_gb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd2 && valid_o && $past(op_i, 2) == 2'd0 && $past(shamt_i, 2) == '0 &&
     $past(vxrm_i, 2) != 2'd3 && $past(sew_i, 2) == 2'd3) |-> (result_o == $past(a_i, 2)));
endmodule

bind fxr_round_avg_unit fxr_round_avg_checker #(.XLEN(XLEN), .SHW(SHW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .sew_i   (sew_i),
  .vxrm_i  (vxrm_i),
  .shamt_i (shamt_i),
  .a_i     (a_i),
  .valid_o (valid_o),
  .result_o(result_o)
);

// File: tb/tb_fxr_round_avg_unit.sv
module tb_fxr_round_avg_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0, sew_i = '0, vxrm_i = '0;
  logic [5:0]  shamt_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int total = 0;
  int bad = 0;

  bit          pv [2];
  logic [63:0] pr [2];
  string       pt [2];
  logic [63:0] last_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxr_round_avg_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .sew_i(sew_i),
    .vxrm_i(vxrm_i), .shamt_i(shamt_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic signed [129:0] sx(input logic [63:0] x, input logic [1:0] sew);
    case (sew)
      2'd0: return {{122{x[7]}}, x[7:0]};
      2'd1: return {{114{x[15]}}, x[15:0]};
      2'd2: return {{98{x[31]}}, x[31:0]};
      default: return {{66{x[63]}}, x};
    endcase
  endfunction

  function automatic logic [63:0] ref_fn(input logic [1:0] op, sew, rm,
                                         input logic [5:0] sh, input logic [63:0] a, b);
    logic signed [129:0] v, fl, rem, unit;
    int g;
    case (op)
      2'd1: begin v = sx(a, sew) + sx(b, sew); g = 1; end
      2'd2: begin v = sx(a, sew) - sx(b, sew); g = 1; end
      default: begin v = sx(a, 2'd3); g = int'(sh); end
    endcase
    fl   = v >>> g;
    unit = 130'sd1 <<< g;
    rem  = v - (fl <<< g);
    case (rm)
      2'd0: if ((rem <<< 1) >= unit) fl = fl + 1;
      2'd1: if ((rem <<< 1) > unit || ((rem <<< 1) == unit && fl[0])) fl = fl + 1;
      2'd2: ;
      default: fl[0] = 1'b1;
    endcase
    return 64'(sx(fl[63:0], sew));
  endfunction

  function automatic string tag_fn(input logic [1:0] op, sew, rm, input logic [5:0] sh);
    string t;
    if (op == 2'd1) t = "R8";
    else if (op == 2'd2) t = "R9";
    else if (sh == 0) t = "R7";
    else case (rm)
      2'd0: t = "R3";
      2'd1: t = "R4";
      2'd2: t = "R5";
      default: t = "R6";
    endcase
    if (sew != 2'd3 || op == 2'd3) t = {t, " R10"};
    return t;
  endfunction

  task automatic step(input bit v, input logic [1:0] op, sew, rm,
                      input logic [5:0] sh, input logic [63:0] a, b);
    @(negedge clk);
    total++;
    if (valid_o !== pv[1]) begin
      bad++;
      $display("FAIL R2 valid_o actual=%0b expected=%0b", valid_o, pv[1]);
    end
    total++;
    if (pv[1]) begin
      if (result_o !== pr[1]) begin
        bad++;
        $display("FAIL %s result actual=%h expected=%h", pt[1], result_o, pr[1]);
      end
      last_res = pr[1];
    end else if (result_o !== last_res) begin
      bad++;
      $display("FAIL R11 held result actual=%h expected=%h", result_o, last_res);
    end
    pv[1] = pv[0]; pr[1] = pr[0]; pt[1] = pt[0];
    pv[0] = v;
    if (v) begin
      pr[0] = ref_fn(op, sew, rm, sh, a, b);
      pt[0] = tag_fn(op, sew, rm, sh);
    end
    valid_i = v; op_i = op; sew_i = sew; vxrm_i = rm; shamt_i = sh; a_i = a; b_i = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (valid_o !== 1'b0 || result_o !== 64'h0) begin
      bad++;
      $display("FAIL R1 reset actual=%0b/%h expected=0/0", valid_o, result_o);
    end
    rst_ni = 1'b1;
    // ties and negative ties with gb = 2, every mode
    for (int m = 0; m < 4; m++) begin
      step(1, 2'd0, 2'd3, 2'(m), 6'd2, 64'd6, 64'd0);
      step(1, 2'd0, 2'd3, 2'(m), 6'd2, 64'd10, 64'd0);
      step(1, 2'd0, 2'd3, 2'(m), 6'd2, -64'sd6, 64'd0);
      step(1, 2'd0, 2'd3, 2'(m), 6'd2, -64'sd10, 64'd0);
      step(1, 2'd0, 2'd3, 2'(m), 6'd0, 64'h8000_0000_0000_0000, 64'd0);
      step(1, 2'd0, 2'd3, 2'(m), 6'd63, 64'hC000_0000_0000_0001, 64'd0);
      step(1, 2'd1, 2'd0, 2'(m), 6'd9, 64'h7F, 64'h7F);
      step(1, 2'd1, 2'd0, 2'(m), 6'd9, 64'h80, 64'h80);
      step(1, 2'd2, 2'd0, 2'(m), 6'd5, 64'h7F, 64'h80);
      step(1, 2'd2, 2'd3, 2'(m), 6'd0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);
      step(1, 2'd1, 2'd3, 2'(m), 6'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF);
      step(0, 2'd2, 2'd1, 2'd3, 6'd7, 64'h1234, 64'h5678);
      step(1, 2'd1, 2'd2, 2'(m), 6'd1, 64'h0000_0000_8000_0001, 64'h0000_0000_8000_0000);
    end
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] ra, rb;
      logic [5:0]  rs;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rs = 6'($urandom);
      if ($urandom_range(0, 7) == 0) rs = 6'd0;
      if ($urandom_range(0, 15) == 0) ra = {ra[63], 63'h0} | 64'(rs != 0 ? (64'd1 << (rs - 1)) : 64'd0);
      step($urandom_range(0, 3) != 0, 2'($urandom), 2'($urandom), 2'($urandom), rs, ra, rb);
    end
    step(0, 2'd0, 2'd0, 2'd0, 6'd0, 64'd0, 64'd0);
    step(0, 2'd0, 2'd0, 2'd0, 6'd0, 64'd0, 64'd0);
    step(0, 2'd0, 2'd0, 2'd0, 6'd0, 64'd0, 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule